// File: doc/BRIEF.md
# Immediate-Controlled Bit Field Extractor

This unit pulls a contiguous bit field out of a 64-bit operand. A 16-bit control word, supplied alongside the operand, packs two numbers. The low byte gives the lowest bit of the field, and the high byte gives how many bits the field spans. The field is returned right-justified and zero-extended. The unit also returns the six arithmetic status flags, formed the way a logical operation forms them. It sits in an execution pipeline behind operand fetch.

Every corner of the control word has a defined result. A starting bit at or beyond the operand width yields zero. A zero length yields zero. A length of 64 or more applies no truncation. A field that runs off the top of the operand returns only the bits that exist. The result and flags are registered, so an accepted operation appears on the outputs one cycle later with its own valid strobe.

Top module: `bfx_extract_unit`

## Requirements
- R1: The control word splits into a start position in bits 7:0 and a field length in bits 15:8, both unsigned.
- R2: A start position of 64 or more gives an all-zero result, whatever the length.
- R3: A length of zero gives an all-zero result, whatever the start position.
- R4: For a start below 64 and a length of 64 or more, the result is the operand shifted right by the start position, with zeros entering from bit 63.
- R5: For a start below 64 and a length from 1 to 63, only the low `length` bits of the shifted operand survive, and every higher result bit is zero.
- R6: A field that extends past bit 63 returns the operand bits from the start position up to bit 63, zero-extended, with no error indication.
- R7: The zero flag is 1 exactly when the result is zero. The sign flag equals result bit 63.
- R8: The carry, overflow and auxiliary-carry flags are always 0 on a valid output.
- R9: The parity flag is 1 when result bits 7:0 hold an even number of ones.
- R10: An operation accepted with in_valid at one clock edge produces out_valid with its result and flags after the next edge. out_valid is 0 after a cycle with no input. Result and flags keep their last values while no new input arrives.
- R11: A synchronous active-high reset drives out_valid to 0 on the edge where it is sampled, even if in_valid is high in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand and control word are valid this cycle |
| in_src | input | 64 | Source operand |
| in_ctrl | input | 16 | Control word: start position in bits 7:0, length in bits 15:8 |
| out_valid | output | 1 | Result and flags belong to an accepted operation |
| out_result | output | 64 | Extracted field, right-justified and zero-extended |
| out_cf | output | 1 | Carry flag, always 0 |
| out_pf | output | 1 | Parity of result bits 7:0, 1 when the count of ones is even |
| out_af | output | 1 | Auxiliary carry flag, always 0 |
| out_zf | output | 1 | Zero flag |
| out_sf | output | 1 | Sign flag, a copy of result bit 63 |
| out_of | output | 1 | Overflow flag, always 0 |

## Verification
Two functions can act on the same operation: the shifter truncates the field at the top of the operand, and the length mask truncates it at `length` bits. Both act together when a field crosses bit 63 with a length below 64. The same holds when an out-of-range start is paired with a length of 64 or more, where the start rule must win over the pass-through. The bench provokes both cases with directed control words such as start 60 with length 10, and start 64 with length 255. It also biases its random control words toward start plus length near 64. Each result is judged against a bit-by-bit reference that copies operand bit start+k into result bit k only while k is below the length and start+k is below 64.

// File: rtl/bfx_pkg.sv
package bfx_pkg;

    localparam int unsigned BFX_DATA_W = 64;
    localparam int unsigned BFX_CTRL_W = 16;

    // Arithmetic status flags as produced by a logical-class operation
    typedef struct packed {
        logic cf;
        logic pf;
        logic af;
        logic zf;
        logic sf;
        logic of;
    } bfx_flags_t;

    localparam bfx_flags_t BFX_FLAGS_CLEAR = '{default: 1'b0};

    // Even parity over one byte: 1 when the count of ones is even
    function automatic logic bfx_even_parity(input logic [7:0] b);
        return ~^b;
    endfunction

endpackage

// File: rtl/bfx_shifter.sv
module bfx_shifter
    import bfx_pkg::*;
#(
    parameter int unsigned DATA_W = BFX_DATA_W,
    parameter int unsigned POS_W  = 8
) (
    input  logic [DATA_W-1:0] src,
    input  logic [POS_W-1:0]  start,
    output logic [DATA_W-1:0] shifted
);
    localparam int unsigned STAGES = $clog2(DATA_W);

    logic [DATA_W-1:0] stg [0:STAGES];
    logic              out_of_range;

    assign stg[0] = src;

    // Logarithmic right shifter, one stage per start-position bit
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        assign stg[s+1] = start[s] ? (stg[s] >> (2 ** s)) : stg[s];
    end

    // Any upper start bit set means the position is at or past DATA_W
    if (POS_W > STAGES) begin : g_oor
        assign out_of_range = |start[POS_W-1:STAGES];
    end else begin : g_no_oor
        assign out_of_range = 1'b0;
    end

    assign shifted = out_of_range ? '0 : stg[STAGES];

endmodule

// File: rtl/bfx_masker.sv
module bfx_masker
    import bfx_pkg::*;
#(
    parameter int unsigned DATA_W = BFX_DATA_W,
    parameter int unsigned POS_W  = 8
) (
    input  logic [DATA_W-1:0] data,
    input  logic [POS_W-1:0]  length,
    output logic [DATA_W-1:0] masked
);
    logic [DATA_W-1:0] keep;

    // Thermometer mask: bit i survives when the length exceeds i.
    // Length 0 clears everything, length >= DATA_W keeps everything.
    for (genvar i = 0; i < DATA_W; i++) begin : g_keep
        assign keep[i] = (int'(length) > i);
    end

    assign masked = data & keep;

    always_comb begin
        if (int'(length) < DATA_W) begin
            // R5
            mask_hi_clear_chk: assert ((masked >> length) == '0);
        end
    end

endmodule

// File: rtl/bfx_flags.sv
module bfx_flags
    import bfx_pkg::*;
#(
    parameter int unsigned DATA_W = BFX_DATA_W
) (
    input  logic [DATA_W-1:0] value,
    output bfx_flags_t        flags
);
    always_comb begin
        flags    = BFX_FLAGS_CLEAR;
        flags.zf = ~|value;
        flags.sf = value[DATA_W-1];
        flags.pf = bfx_even_parity(value[7:0]);
    end

endmodule

// File: rtl/bfx_extract_unit.sv
module bfx_extract_unit
    import bfx_pkg::*;
#(
    parameter int unsigned DATA_W = BFX_DATA_W,
    parameter int unsigned CTRL_W = BFX_CTRL_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_src,
    input  logic [CTRL_W-1:0] in_ctrl,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_result,
    output logic              out_cf,
    output logic              out_pf,
    output logic              out_af,
    output logic              out_zf,
    output logic              out_sf,
    output logic              out_of
);
    localparam int unsigned POS_W = CTRL_W / 2;

    logic [POS_W-1:0]  ctl_start;
    logic [POS_W-1:0]  ctl_len;
    logic [DATA_W-1:0] shifted;
    logic [DATA_W-1:0] field;
    bfx_flags_t        flags_c;

    logic              valid_q;
    logic [DATA_W-1:0] result_q;
    bfx_flags_t        flags_q;

    assign ctl_start = in_ctrl[POS_W-1:0];
    assign ctl_len   = in_ctrl[CTRL_W-1:POS_W];

    bfx_shifter #(.DATA_W(DATA_W), .POS_W(POS_W)) u_shift (
        .src     (in_src),
        .start   (ctl_start),
        .shifted (shifted)
    );

    bfx_masker #(.DATA_W(DATA_W), .POS_W(POS_W)) u_mask (
        .data   (shifted),
        .length (ctl_len),
        .masked (field)
    );

    bfx_flags #(.DATA_W(DATA_W)) u_flags (
        .value (field),
        .flags (flags_c)
    );

    always_ff @(posedge clk) begin
        if (rst) valid_q <= 1'b0;
        else     valid_q <= in_valid;
    end

    always_ff @(posedge clk) begin
        if (in_valid) begin
            result_q <= field;
            flags_q  <= flags_c;
        end
    end

    assign out_valid  = valid_q;
    assign out_result = result_q;
    assign out_cf     = flags_q.cf;
    assign out_pf     = flags_q.pf;
    assign out_af     = flags_q.af;
    assign out_zf     = flags_q.zf;
    assign out_sf     = flags_q.sf;
    assign out_of     = flags_q.of;

    // R10
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R10
    valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R10
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(out_result) && $stable(out_zf) && $stable(out_pf)));

    // R2
    start_oor_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && int'(ctl_start) >= DATA_W) |=> (out_result == '0));

    // R3
    len_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && ctl_len == '0) |=> (out_result == '0));

    // R7
    zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_zf == (out_result == '0)));

    // R7
    sign_flag_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_sf == out_result[DATA_W-1]));

    // R8
    fixed_flags_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (!out_cf && !out_of && !out_af));

    // R11
    reset_clear_chk: assert property (@(posedge clk)
        $past(rst) |-> !out_valid);

endmodule

// File: tb/test_bfx_extract_unit.sv
module test_bfx_extract_unit;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [63:0] in_src;
    logic [15:0] in_ctrl;
    logic        out_valid;
    logic [63:0] out_result;
    logic        out_cf, out_pf, out_af, out_zf, out_sf, out_of;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    bfx_extract_unit i_bfx_extract_unit (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_src     (in_src),
        .in_ctrl    (in_ctrl),
        .out_valid  (out_valid),
        .out_result (out_result),
        .out_cf     (out_cf),
        .out_pf     (out_pf),
        .out_af     (out_af),
        .out_zf     (out_zf),
        .out_sf     (out_sf),
        .out_of     (out_of)
    );

    // Reference: result bit k = src bit start+k while k < length and start+k < 64
    function automatic logic [63:0] ref_field(input logic [63:0] s, input logic [15:0] c);
        int st = int'(c[7:0]);
        int ln = int'(c[15:8]);
        logic [63:0] r = '0;
        for (int k = 0; k < 64; k++) begin
            if (k < ln && st + k < 64) r[k] = s[st + k];
        end
        return r;
    endfunction

    function automatic logic ref_even(input logic [7:0] b);
        int n = 0;
        for (int k = 0; k < 8; k++) n += int'(b[k]);
        return (n % 2) == 0;
    endfunction

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Compare every output against the reference for one operation
    task automatic check_out(input logic [63:0] s, input logic [15:0] c, input string req);
        logic [63:0] e = ref_field(s, c);
        chk("R10", "out_valid", 64'(out_valid), 64'd1);
        chk(req,   "result",    out_result, e);
        chk("R7",  "zf",        64'(out_zf), 64'(e == 64'd0));
        chk("R7",  "sf",        64'(out_sf), 64'(e[63]));
        chk("R9",  "pf",        64'(out_pf), 64'(ref_even(e[7:0])));
        chk("R8",  "cf/of/af",  {61'd0, out_cf, out_of, out_af}, 64'd0);
    endtask

    task automatic do_op(input logic [63:0] s, input logic [15:0] c, input string req);
        @(negedge clk);
        in_valid = 1'b1;
        in_src   = s;
        in_ctrl  = c;
        @(negedge clk);
        in_valid = 1'b0;
        in_src   = ~s;
        in_ctrl  = 16'hFFFF;
        check_out(s, c, req);
    endtask

    function automatic logic [15:0] rand_ctrl();
        int sel = int'($urandom_range(0, 9));
        logic [7:0] st;
        logic [7:0] ln;
        if (sel < 6) begin
            st = 8'($urandom_range(0, 63));
            ln = 8'($urandom_range(0, 70) - int'(st) + 64 > 255 ? 255 : $urandom_range(1, 70));
        end else if (sel < 8) begin
            st = 8'($urandom_range(0, 63));
            ln = 8'(64 - int'(st) + int'($urandom_range(0, 4)) - 2);
        end else begin
            st = 8'($urandom_range(0, 255));
            ln = 8'($urandom_range(0, 255));
        end
        return {ln, st};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL R10 watchdog: actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [63:0] pend_s;
        logic [15:0] pend_c;
        logic [63:0] held;
        void'($urandom(32'h5EED_0B1F));
        rst      = 1'b1;
        in_valid = 1'b0;
        in_src   = '0;
        in_ctrl  = '0;
        repeat (3) @(negedge clk);
        // R11: reset state
        chk("R11", "out_valid after reset", 64'(out_valid), 64'd0);
        rst = 1'b0;

        // R1: field positions: start 8, length 4 picks nibble at bits 11:8
        do_op(64'h0000_0000_0000_0A00, 16'h0408, "R1");
        // R2: out-of-range starts
        do_op(64'hFFFF_FFFF_FFFF_FFFF, 16'h2040, "R2");
        do_op(64'hFFFF_FFFF_FFFF_FFFF, 16'hFF40, "R2");
        do_op(64'hFFFF_FFFF_FFFF_FFFF, 16'h01FF, "R2");
        // R3: zero length
        do_op(64'hFFFF_FFFF_FFFF_FFFF, 16'h0000, "R3");
        do_op(64'hFFFF_FFFF_FFFF_FFFF, 16'h0005, "R3");
        // R4: length 64 and above, no mask
        do_op(64'h8123_4567_89AB_CDEF, 16'h4000, "R4");
        do_op(64'h8123_4567_89AB_CDEF, 16'hFF04, "R4");
        // R5: partial masks
        do_op(64'hFFFF_FFFF_FFFF_FFFF, 16'h0100, "R5");
        do_op(64'hFFFF_FFFF_FFFF_FFFF, 16'h3F00, "R5");
        do_op(64'hDEAD_BEEF_CAFE_F00D, 16'h1010, "R5");
        // R6: field crossing bit 63
        do_op(64'hF000_0000_0000_0000, 16'h0A3C, "R6");
        do_op(64'h8000_0000_0000_0000, 16'h083F, "R6");
        // R7/R9: sign set, parity odd and even
        do_op(64'h8000_0000_0000_0001, 16'h4000, "R7");
        do_op(64'h0000_0000_0000_0003, 16'h4000, "R9");

        // R10: hold while idle
        held = ref_field(64'h1234_5678_9ABC_DEF0, 16'h2004);
        do_op(64'h1234_5678_9ABC_DEF0, 16'h2004, "R10");
        @(negedge clk);
        chk("R10", "out_valid idle", 64'(out_valid), 64'd0);
        chk("R10", "result held", out_result, held);

        // R11: reset beats a valid input
        @(negedge clk);
        in_valid = 1'b1;
        in_src   = 64'hFFFF;
        in_ctrl  = 16'h4000;
        rst      = 1'b1;
        @(negedge clk);
        chk("R11", "out_valid under reset", 64'(out_valid), 64'd0);
        rst      = 1'b0;
        in_valid = 1'b0;

        // R10/R4/R5/R6: back-to-back random stream
        @(negedge clk);
        pend_s = {$urandom(), $urandom()};
        pend_c = rand_ctrl();
        in_valid = 1'b1;
        in_src   = pend_s;
        in_ctrl  = pend_c;
        for (int n = 0; n < 3000; n++) begin
            logic [63:0] ns = {$urandom(), $urandom()};
            logic [15:0] nc = rand_ctrl();
            @(negedge clk);
            check_out(pend_s, pend_c, "R5");
            pend_s  = ns;
            pend_c  = nc;
            in_src  = ns;
            in_ctrl = nc;
        end
        @(negedge clk);
        check_out(pend_s, pend_c, "R6");
        in_valid = 1'b0;
        @(negedge clk);
        chk("R10", "out_valid after stream", 64'(out_valid), 64'd0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule